// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single queue cell that threads running on different processors use to pass data words to each other and to wait on each other. It holds a small power-of-two queue of data words together with a tag made up of an empty flag, a full flag, a trap flag, a constant FIFO-type flag, the current fill count and the encoded queue depth.

Each access selects one of several views of the same cell. A raw view reads the head entry or patches the newest entry without moving any pointers. A tag view reads or rewrites the flags. Two empty/full views push or pop with flow-control side effects. One of them waits, and the other returns at once. Counting-semaphore views exist in the view code space, but on this cell they read zero and do nothing.

A waiting access that cannot complete returns a block response, and the cell records the requester's ID in a set of waiters. The next empty/full access that completes releases the whole set with a one-cycle wake pulse vector. Halting and restarting the requesters is left to the surrounding logic.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the tag reads as: empty flag 1, FIFO-type flag 1, depth field equal to log2(DEPTH), fill count 0, full flag 0, trap flag 0. The wake vector is 0 and no response is pending. With the default DEPTH of 8 the tag word is 0x30020001.
- R2: A tag-view read (view code 1) returns a word laid out as follows. Bits 31:28 hold log2(DEPTH). The fill count starts at bit 18. Bit 17 is the FIFO-type flag, always 1. Bit 16 is the trap flag, bit 1 the full flag and bit 0 the empty flag. All other bits are 0.
- R3: A tag-view write loads the trap flag from bit 16, the empty flag from bit 0 and the full flag from bit 1 of the write data. When the loaded empty flag is 1, the fill count is cleared to 0.
- R4: A raw-view read (view code 0) returns the head entry and does not pop it. A raw-view write replaces the newest queued entry, and only does so while the fill count is nonzero.
- R5: An empty/full write clears the empty flag. If it is not blocked, it appends the data at the tail when the queue is not full, and it sets the full flag when the count reaches DEPTH. A non-waiting write (view code 3) to a full queue stores nothing.
- R6: An empty/full read clears the full flag. If it is not blocked, it pops the head in first-in first-out order, and it sets the empty flag when the count reaches 0. A non-waiting read (view code 3) of an empty queue returns 0.
- R7: A waiting read (view code 2) while the empty flag is 1, or a waiting write (view code 2) while the full flag is 1, returns a block response with data 0 and adds the requester ID to the waiter set. No other view ever blocks.
- R8: Every empty/full access that is not blocked drives the wake vector, for one cycle, to the waiter set as it stood before the access, and then empties the waiter set.
- R9: Semaphore views (codes 4 and 5) and the unused codes 6 and 7 read as 0, never block and change no state.
- R10: Each request is answered exactly one cycle later on rsp_valid_o, with the data, the block flag and the wake vector valid in the same cycle.
- R11: The head and tail positions wrap modulo DEPTH, so first-in first-out order holds across the end of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| req_we_i | input | 1 | 1 = write access, 0 = read access |
| req_view_i | input | 3 | View code (0 raw, 1 tag, 2 empty/full waiting, 3 empty/full non-waiting, 4/5 semaphore) |
| req_id_i | input | ID_W | Requester ID |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_block_o | output | 1 | The access could not complete and was recorded as a waiter |
| rsp_rdata_o | output | DATA_W | Read data |
| wake_o | output | 2**ID_W | One-cycle pulse vector of the released waiters |

## Verification
A completing empty/full access can release waiters and change the queue flags in the same cycle. For example, a push that clears the empty flag also releases readers that had blocked on that empty flag, and a non-waiting write to a full queue releases a blocked writer while storing nothing. The bench parks several requester IDs with waiting reads on an empty cell, then issues one push. It judges that single response cycle by the wake vector, which must equal the parked set. In a later tag read, the count and the flags must show the push.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
   // view codes carried on req_view_i
   localparam logic [2:0] VIEW_RAW     = 3'd0;
   localparam logic [2:0] VIEW_TAG     = 3'd1;
   localparam logic [2:0] VIEW_EF_WAIT = 3'd2;
   localparam logic [2:0] VIEW_EF_POLL = 3'd3;

   // tag word layout
   localparam int TAG_DEPTH_LSB = 28;
   localparam int TAG_DEPTH_W   = 4;
   localparam int TAG_CNT_LSB   = 18;
   localparam int TAG_CNT_MAXW  = 10;
   localparam int TAG_FIFO_BIT  = 17;
   localparam int TAG_TRAP_BIT  = 16;
   localparam int TAG_FULL_BIT  = 1;
   localparam int TAG_EMPTY_BIT = 0;

   typedef struct packed {
      logic trap;
      logic full;
      logic empty;
   } cell_flags_t;
endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [PTR_W-1:0]  waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]  raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mem_q[e] <= '0;
         end else if (we_i && (waddr_i == PTR_W'(e))) begin
            mem_q[e] <= wdata_i;
         end
      end
   end

   assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/itc_cell_waitset.sv
module itc_cell_waitset #(
   parameter int ID_W  = 6,
   localparam int NREQ = 1 << ID_W
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            block_i,
   input  logic [ID_W-1:0] id_i,
   input  logic            wake_i,
   output logic [NREQ-1:0] wake_o
);
   logic [NREQ-1:0] set_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         set_q  <= '0;
         wake_o <= '0;
      end else begin
         wake_o <= '0;
         if (block_i) begin
            set_q[id_i] <= 1'b1;
         end else if (wake_i) begin
            wake_o <= set_q;
            set_q  <= '0;
         end
      end
   end
endmodule

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
   import itc_cell_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [2:0]        view_i,
   input  cell_flags_t       ctl_flags_i,
   input  logic [DATA_W-1:0] st_rdata_i,
   output logic              st_we_o,
   output logic [PTR_W-1:0]  st_waddr_o,
   output logic [PTR_W-1:0]  st_raddr_o,
   output logic [DATA_W-1:0] rd_val_o,
   output logic              blk_o,
   output logic              wake_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [PTR_W-1:0] out_q, out_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   cell_flags_t      flg_q, flg_d;
   logic [PTR_W-1:0] tail, newest;
   logic [DATA_W-1:0] tag_word;
   logic             waiting;

   assign tail       = out_q + cnt_q[PTR_W-1:0];
   assign newest     = tail - PTR_W'(1);
   assign st_raddr_o = out_q;
   assign cnt_o      = cnt_q;
   assign waiting    = (view_i == VIEW_EF_WAIT);

   always_comb begin
      tag_word = '0;
      tag_word[TAG_DEPTH_LSB +: TAG_DEPTH_W] = TAG_DEPTH_W'(PTR_W);
      tag_word[TAG_CNT_LSB +: CNT_W]         = cnt_q;
      tag_word[TAG_FIFO_BIT]                 = 1'b1;
      tag_word[TAG_TRAP_BIT]                 = flg_q.trap;
      tag_word[TAG_FULL_BIT]                 = flg_q.full;
      tag_word[TAG_EMPTY_BIT]                = flg_q.empty;
   end

   always_comb begin
      out_d      = out_q;
      cnt_d      = cnt_q;
      flg_d      = flg_q;
      st_we_o    = 1'b0;
      st_waddr_o = tail;
      rd_val_o   = '0;
      blk_o      = 1'b0;
      wake_o     = 1'b0;
      if (req_i) begin
         case (view_i)
            VIEW_RAW: begin
               if (!we_i) begin
                  rd_val_o = st_rdata_i;
               end else if (cnt_q != '0) begin
                  st_we_o    = 1'b1;
                  st_waddr_o = newest;
               end
            end
            VIEW_TAG: begin
               if (!we_i) begin
                  rd_val_o = tag_word;
               end else begin
                  flg_d = ctl_flags_i;
                  if (ctl_flags_i.empty) cnt_d = '0;
               end
            end
            VIEW_EF_WAIT, VIEW_EF_POLL: begin
               if (we_i) begin
                  flg_d.empty = 1'b0;
                  if (waiting && flg_q.full) begin
                     blk_o = 1'b1;
                  end else begin
                     wake_o = 1'b1;
                     if (cnt_q != CNT_FULL) begin
                        st_we_o = 1'b1;
                        cnt_d   = cnt_q + CNT_W'(1);
                     end
                     if (cnt_d == CNT_FULL) flg_d.full = 1'b1;
                  end
               end else begin
                  flg_d.full = 1'b0;
                  if (waiting && flg_q.empty) begin
                     blk_o = 1'b1;
                  end else begin
                     wake_o = 1'b1;
                     if (cnt_q != '0) begin
                        rd_val_o = st_rdata_i;
                        out_d    = out_q + PTR_W'(1);
                        cnt_d    = cnt_q - CNT_W'(1);
                     end
                     if (cnt_d == '0) flg_d.empty = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q <= '0;
         cnt_q <= '0;
         flg_q <= '{trap: 1'b0, full: 1'b0, empty: 1'b1};
      end else begin
         out_q <= out_d;
         cnt_q <= cnt_d;
         flg_q <= flg_d;
      end
   end
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
   import itc_cell_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   parameter int ID_W   = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1,
   localparam int NREQ  = 1 << ID_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [2:0]        req_view_i,
   input  logic [ID_W-1:0]   req_id_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_block_o,
   output logic [DATA_W-1:0] rsp_rdata_o,
   output logic [NREQ-1:0]   wake_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (CNT_W > TAG_CNT_MAXW || PTR_W >= (1 << TAG_DEPTH_W)) begin : g_bad_tag
      $error("DEPTH does not fit the tag fields");
   end
   if (DATA_W < TAG_DEPTH_LSB + TAG_DEPTH_W) begin : g_bad_width
      $error("DATA_W too narrow for the tag word");
   end
   if (ID_W < 1 || ID_W > 8) begin : g_bad_id
      $error("ID_W out of range");
   end

   logic              st_we;
   logic [PTR_W-1:0]  st_waddr, st_raddr;
   logic [DATA_W-1:0] st_rdata, rd_val;
   logic              blk, wake_go;
   logic [CNT_W-1:0]  cell_cnt;
   cell_flags_t       ctl_flags;

   assign ctl_flags = '{trap:  req_wdata_i[TAG_TRAP_BIT],
                        full:  req_wdata_i[TAG_FULL_BIT],
                        empty: req_wdata_i[TAG_EMPTY_BIT]};

   itc_cell_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .we_i        (req_we_i),
      .view_i      (req_view_i),
      .ctl_flags_i (ctl_flags),
      .st_rdata_i  (st_rdata),
      .st_we_o     (st_we),
      .st_waddr_o  (st_waddr),
      .st_raddr_o  (st_raddr),
      .rd_val_o    (rd_val),
      .blk_o       (blk),
      .wake_o      (wake_go),
      .cnt_o       (cell_cnt)
   );

   itc_cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (st_we),
      .waddr_i (st_waddr),
      .wdata_i (req_wdata_i),
      .raddr_i (st_raddr),
      .rdata_o (st_rdata)
   );

   itc_cell_waitset #(.ID_W(ID_W)) i_waitset (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .block_i (blk),
      .id_i    (req_id_i),
      .wake_i  (wake_go),
      .wake_o  (wake_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_block_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_i;
         rsp_block_o <= blk;
         rsp_rdata_o <= rd_val;
      end
   end
endmodule

// File: rtl/itc_fifo_cell_chk.sv
module itc_fifo_cell_chk #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   parameter int ID_W   = 6,
   localparam int CNT_W = $clog2(DEPTH) + 1,
   localparam int NREQ  = 1 << ID_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_i,
   input logic [2:0]        req_view_i,
   input logic              rsp_valid_o,
   input logic              rsp_block_o,
   input logic [DATA_W-1:0] rsp_rdata_o,
   input logic [NREQ-1:0]   wake_o,
   input logic [CNT_W-1:0]  cnt_i
);
   assert_rsp_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> rsp_valid_o);
   assert_rsp_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !rsp_valid_o);
   assert_block_view_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && req_view_i != 3'd2) |=> !rsp_block_o);
   assert_block_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_block_o |-> (rsp_rdata_o == '0));
   assert_sema_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && req_view_i[2]) |=> (rsp_rdata_o == '0));
   assert_sema_still_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && req_view_i[2]) |=> $stable(cnt_i));
   assert_wake_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_o != '0) |=> (wake_o == '0));
   assert_wake_noblock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_o != '0) |-> !rsp_block_o);
   assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= CNT_W'(DEPTH));
endmodule

bind itc_fifo_cell itc_fifo_cell_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ID_W(ID_W)) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_i       (req_i),
   .req_view_i  (req_view_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_block_o (rsp_block_o),
   .rsp_rdata_o (rsp_rdata_o),
   .wake_o      (wake_o),
   .cnt_i       (cell_cnt)
);

// File: tb/test_itc_fifo_cell.sv
module test_itc_fifo_cell;
   localparam int DATA_W = 64;
   localparam int ID_W   = 6;
   localparam int NREQ   = 1 << ID_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic              we = 1'b0;
   logic [2:0]        view = 3'd0;
   logic [ID_W-1:0]   id = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              rsp_valid, rsp_block;
   logic [DATA_W-1:0] rsp_rdata;
   logic [NREQ-1:0]   wake;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   itc_fifo_cell #(.DATA_W(DATA_W), .DEPTH(8), .ID_W(ID_W)) i_itc_fifo_cell (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we), .req_view_i(view),
      .req_id_i(id), .req_wdata_i(wdata), .rsp_valid_o(rsp_valid),
      .rsp_block_o(rsp_block), .rsp_rdata_o(rsp_rdata), .wake_o(wake));

   typedef struct packed {
      logic        wr;
      logic [2:0]  vw;
      logic [5:0]  rid;
      logic [63:0] wd;
      logic [63:0] exp;
      logic        blk;
   } vec_t;

   // walked from reset; tag word for DEPTH 8 has 0x3 at bits 31:28
   localparam vec_t VECS [12] = '{
      '{1'b0, 3'd1, 6'd0, 64'h0,  64'h3002_0001, 1'b0},  // R1 R2 reset tag
      '{1'b1, 3'd3, 6'd0, 64'h11, 64'h0,         1'b0},  // R5 push
      '{1'b1, 3'd3, 6'd0, 64'h22, 64'h0,         1'b0},  // R5 push
      '{1'b0, 3'd1, 6'd0, 64'h0,  64'h300A_0000, 1'b0},  // R2 count 2
      '{1'b0, 3'd0, 6'd0, 64'h0,  64'h11,        1'b0},  // R4 head peek
      '{1'b1, 3'd0, 6'd0, 64'h2A, 64'h0,         1'b0},  // R4 patch newest
      '{1'b0, 3'd2, 6'd0, 64'h0,  64'h11,        1'b0},  // R6 pop
      '{1'b0, 3'd2, 6'd0, 64'h0,  64'h2A,        1'b0},  // R4 R6 patched pop
      '{1'b0, 3'd3, 6'd0, 64'h0,  64'h0,         1'b0},  // R6 empty poll
      '{1'b0, 3'd4, 6'd0, 64'h0,  64'h0,         1'b0},  // R9 semaphore
      '{1'b0, 3'd1, 6'd0, 64'h0,  64'h3002_0001, 1'b0},  // R6 empty set
      '{1'b0, 3'd2, 6'd3, 64'h0,  64'h0,         1'b1}   // R7 blocked read
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic [2:0] v, input logic [5:0] r,
                         input logic [63:0] d);
      @(negedge clk);
      req = 1'b1; we = w; view = v; id = r; wdata = d;
      @(posedge clk);
      #1;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   // access leaves outputs of the answered cycle stable until the next posedge
   task automatic idle();
      @(negedge clk);
      req = 1'b0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
      check("R1 wake", 64'(wake), 64'h0);

      foreach (VECS[k]) begin
         access(VECS[k].wr, VECS[k].vw, VECS[k].rid, VECS[k].wd);
         check($sformatf("R10 vec%0d valid", k), 64'(rsp_valid), 64'h1);
         check($sformatf("vec%0d data", k), rsp_rdata, VECS[k].exp);
         check($sformatf("R7 vec%0d block", k), 64'(rsp_block), 64'(VECS[k].blk));
      end
      idle();
      check("R10 idle valid", 64'(rsp_valid), 64'h0);

      // second waiter, then one push releases both in the same cycle
      access(1'b0, 3'd2, 6'd9, 64'h0);
      check("R7 second block", 64'(rsp_block), 64'h1);
      access(1'b1, 3'd3, 6'd1, 64'h55);
      check("R8 wake set", wake, (64'h1 << 3) | (64'h1 << 9));
      check("R8 no block", 64'(rsp_block), 64'h0);
      idle();
      check("R8 pulse ends", wake, 64'h0);
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R5 empty cleared", rsp_rdata, 64'h3006_0000);

      // fill across the storage end (head is at slot 2)
      for (int i = 0; i < 7; i++) access(1'b1, 3'd3, 6'd0, 64'h100 + 64'(i));
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R5 full tag", rsp_rdata, 64'h3022_0002);
      access(1'b1, 3'd2, 6'd12, 64'hBAD);
      check("R7 write blocks", 64'(rsp_block), 64'h1);
      access(1'b1, 3'd3, 6'd0, 64'hBEEF);
      check("R8 poll write wakes", wake, 64'h1 << 12);
      check("R5 poll on full no block", 64'(rsp_block), 64'h0);
      access(1'b0, 3'd3, 6'd0, 64'h0);
      check("R11 first pop", rsp_rdata, 64'h55);
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R6 full cleared", rsp_rdata, 64'h301E_0000);
      for (int i = 0; i < 7; i++) begin
         access(1'b0, 3'd2, 6'd0, 64'h0);
         check($sformatf("R11 wrap pop %0d", i), rsp_rdata, 64'h100 + 64'(i));
      end
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R6 drained", rsp_rdata, 64'h3002_0001);

      // tag rewrites
      access(1'b1, 3'd3, 6'd0, 64'hA);
      access(1'b1, 3'd3, 6'd0, 64'hB);
      access(1'b1, 3'd1, 6'd0, 64'h1_0002);
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R3 trap full load", rsp_rdata, 64'h300B_0002);
      access(1'b1, 3'd1, 6'd0, 64'h1);
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R3 empty clears count", rsp_rdata, 64'h3002_0001);

      // semaphore and unused views leave the cell alone
      access(1'b1, 3'd3, 6'd0, 64'h77);
      access(1'b1, 3'd4, 6'd0, 64'h1);
      access(1'b1, 3'd5, 6'd0, 64'h1);
      access(1'b0, 3'd6, 6'd0, 64'h0);
      check("R9 unused view", rsp_rdata, 64'h0);
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R9 tag unchanged", rsp_rdata, 64'h3006_0000);
      access(1'b0, 3'd0, 6'd0, 64'h0);
      check("R9 data unchanged", rsp_rdata, 64'h77);

      // reset in mid run
      access(1'b0, 3'd2, 6'd20, 64'h0);
      access(1'b0, 3'd2, 6'd20, 64'h0);
      check("R7 parked before reset", 64'(rsp_block), 64'h1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 reset valid", 64'(rsp_valid), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b0, 3'd1, 6'd0, 64'h0);
      check("R1 reset tag", rsp_rdata, 64'h3002_0001);
      access(1'b1, 3'd3, 6'd0, 64'h5);
      check("R1 waiters cleared", wake, 64'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule